// File: doc/BRIEF.md
# Playback Byte-Stream Sample Unpacker

This block sits behind an 8-bit programmed-I/O data port and rebuilds signed 16-bit left and right playback samples from the bytes software writes there. A stereo flag and a 2-bit layout code select how the bytes are read. The layouts are 8-bit unsigned linear, 8-bit mu-law companded and 16-bit two's-complement linear sent low byte first. Each layout can be mono or stereo. Once every byte of a pair has arrived, the pair is presented with a valid flag. It stays there until the downstream side signals ready.

The same port address also serves capture. A read strobe returns the capture byte offered by the capture side, and playback writes and capture reads do not interact. If software keeps writing while a finished pair is still waiting for a consumer, those writes are lost and a sticky overrun flag records the loss.

Top module: `pio_sample_unpacker`

## Requirements
- R1: After reset, out_valid and overrun are 0.
- R2: With layout code 00, each byte b becomes the sample {~b[7], b[6:0], 8'h00}.
- R3: With layout code 01, each byte is complemented to u, giving sign u[7], exponent u[6:4] and mantissa u[3:0]. The magnitude is (((mantissa<<3)+132)<<exponent)-132, and the sample is the negated magnitude when the sign is 1.
- R4: With layout code 10, two bytes make one sample, the first byte being bits 7:0 and the second bits 15:8.
- R5: In stereo the first sample of a pair is the left channel and the second is the right. In mono the single sample is driven on both channels.
- R6: out_valid rises only when the last byte of a pair is written. A pair takes 1 byte (8-bit mono), 2 bytes (8-bit stereo or 16-bit mono) or 4 bytes (16-bit stereo).
- R7: A change of the stereo flag or layout code discards any partly assembled pair. A write in the cycle of the change is the first byte under the new layout.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_left and out_right hold their values.
- R9: A write that arrives while a pair is waiting (out_valid 1, out_ready 0) is dropped and sets overrun. Overrun then stays 1 until reset.
- R10: Writes with layout code 11 are ignored and produce no pair.
- R11: rd_data equals cap_byte while rd_en is 1 and is 8'h00 otherwise.
- R12: A pair can complete in the same cycle that the previous pair is taken. With out_ready held at 1, one mono 8-bit byte per cycle gives one pair per cycle, none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe to the data port |
| wr_data | input | 8 | Written playback byte |
| rd_en | input | 1 | Read strobe on the data port |
| cap_byte | input | 8 | Capture byte offered by the capture side |
| rd_data | output | 8 | Data returned on a read |
| stereo | input | 1 | 1 = stereo, 0 = mono |
| fmt | input | 2 | Layout: 00 unsigned 8-bit, 01 mu-law, 10 16-bit low byte first, 11 reserved |
| out_ready | input | 1 | Downstream accepts the current pair |
| out_valid | output | 1 | A complete pair is present |
| out_left | output | 16 | Left sample |
| out_right | output | 16 | Right sample |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
Two events can fall on the same clock edge: the completion of a new pair and the downstream taking of the previous one. They are provoked by writing mono 8-bit bytes on consecutive cycles with out_ready held high, so every edge both retires a pair and loads the next. A scoreboard judges the result: it expects each written byte to emerge as its own pair, in order, with none missing or repeated. The opposite collision, a write arriving while a pair waits with out_ready low, is judged at the ports. The held pair must remain unchanged, the late byte must never appear, and overrun must rise and persist.

// File: rtl/pio_sample_unpacker.sv
module pio_sample_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic [7:0]  cap_byte,
  output logic [7:0]  rd_data,
  input  logic        stereo,
  input  logic [1:0]  fmt,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [15:0] out_left,
  output logic [15:0] out_right,
  output logic        overrun
);

  function automatic logic [15:0] mu_expand(input logic [7:0] b);
    logic [7:0]  u;
    logic [15:0] base;
    logic [15:0] mag;
    u    = ~b;
    base = {8'd0, ({1'b0, u[3:0], 3'b000} + 8'd132)};
    mag  = (base << u[6:4]) - 16'd132;
    return u[7] ? -mag : mag;
  endfunction

  logic [2:0]  cfg_q;
  logic [1:0]  cnt;
  logic [7:0]  lo_q;
  logic [15:0] left_q;

  wire [2:0]  cfg     = {stereo, fmt};
  wire        cfg_chg = cfg != cfg_q;
  wire [1:0]  idx     = cfg_chg ? 2'd0 : cnt;
  wire        pend    = out_valid && !out_ready;
  wire        wide    = fmt == 2'b10;
  wire        fmt_ok  = fmt != 2'b11;
  wire        take    = wr_en && fmt_ok && !pend;
  wire [1:0]  last    = wide ? (stereo ? 2'd3 : 2'd1) : (stereo ? 2'd1 : 2'd0);
  wire        done    = take && (idx == last);
  wire        at_samp = !wide || idx[0];

  wire [15:0] lin8 = {~wr_data[7], wr_data[6:0], 8'h00};
  wire [15:0] samp = wide ? {wr_data, lo_q} : (fmt[0] ? mu_expand(wr_data) : lin8);

  assign rd_data = rd_en ? cap_byte : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= 3'b000;
      cnt       <= 2'd0;
      lo_q      <= 8'h00;
      left_q    <= 16'h0000;
      out_valid <= 1'b0;
      out_left  <= 16'h0000;
      out_right <= 16'h0000;
      overrun   <= 1'b0;
    end else begin
      cfg_q <= cfg;
      if (cfg_chg) cnt <= 2'd0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (wr_en && fmt_ok && pend) overrun <= 1'b1;
      if (take) begin
        cnt <= done ? 2'd0 : idx + 2'd1;
        if (wide && !idx[0]) lo_q <= wr_data;
        if (!done && at_samp) left_q <= samp;
        if (done) begin
          out_valid <= 1'b1;
          out_left  <= stereo ? left_q : samp;
          out_right <= samp;
        end
      end
    end
  end

endmodule

// File: rtl/pio_sample_unpacker_chk.sv
module pio_sample_unpacker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        stereo,
  input logic [1:0]  fmt,
  input logic        out_ready,
  input logic        out_valid,
  input logic [15:0] out_left,
  input logic [15:0] out_right,
  input logic        overrun
);

  // R8
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wr_en && out_valid && !out_ready));

  // R6
  valid_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wr_en));

  // R5
  mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stereo && !fmt[1] && !(out_valid && !out_ready)) |=> (out_valid && out_left == out_right));

  // R10
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt == 2'b11 && !out_valid) |=> !out_valid);

endmodule

bind pio_sample_unpacker pio_sample_unpacker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stereo(stereo), .fmt(fmt),
  .out_ready(out_ready), .out_valid(out_valid), .out_left(out_left),
  .out_right(out_right), .overrun(overrun)
);

// File: tb/pio_sample_unpacker_bench.sv
module pio_sample_unpacker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_en = 1'b0;
  logic [7:0]  cap_byte = 8'h00;
  logic [7:0]  rd_data;
  logic        stereo = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [15:0] out_left, out_right;
  logic        overrun;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { logic [15:0] l; logic [15:0] r; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_sample_unpacker u_pio_sample_unpacker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .cap_byte(cap_byte), .rd_data(rd_data), .stereo(stereo), .fmt(fmt),
    .out_ready(out_ready), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .overrun(overrun)
  );

  function automatic logic [15:0] ref_lin(input logic [7:0] b);
    return {~b[7], b[6:0], 8'h00};
  endfunction

  function automatic logic [15:0] ref_mu(input logic [7:0] b);
    int u, m, e, mag;
    u = ~b & 8'hFF;
    e = (u >> 4) & 7;
    m = u & 15;
    mag = (((m << 3) + 132) << e) - 132;
    if (u >= 128) mag = -mag;
    return mag[15:0];
  endfunction

  function automatic logic [15:0] ref8(input logic [1:0] f, input logic [7:0] b);
    return f[0] ? ref_mu(b) : ref_lin(b);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r, input string tag);
    exp_t e;
    e.l = l; e.r = r; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  task automatic pair8(input logic st, input logic [1:0] f, input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    stereo = st; fmt = f; wr_en = 1'b0;
    wr(a);
    if (st) begin
      wr(b);
      push(ref8(f, a), ref8(f, b), tag);
    end else begin
      push(ref8(f, a), ref8(f, a), tag);
    end
    idle(2);
  endtask

  task automatic pair16(input logic st, input logic [15:0] l, input logic [15:0] r, input string tag);
    @(negedge clk);
    stereo = st; fmt = 2'b10; wr_en = 1'b0;
    wr(l[7:0]); wr(l[15:8]);
    if (st) begin
      wr(r[7:0]); wr(r[15:8]);
      push(l, r, tag);
    end else begin
      push(l, l, tag);
    end
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6: actual unexpected pair %0h/%0h expected none", out_left, out_right);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " left"}, {16'h0, out_left}, {16'h0, e.l});
        check({e.tag, " right"}, {16'h0, out_right}, {16'h0, e.r});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    check("R1 valid", {31'h0, out_valid}, 32'h0);
    check("R1 overrun", {31'h0, overrun}, 32'h0);

    // R2 unsigned 8-bit, mono and stereo
    pair8(1'b0, 2'b00, 8'h00, 8'h00, "R2 mono 00");
    pair8(1'b0, 2'b00, 8'h80, 8'h00, "R2 mono 80");
    pair8(1'b0, 2'b00, 8'hFF, 8'h00, "R2 mono FF");
    pair8(1'b1, 2'b00, 8'h01, 8'hC3, "R5 stereo lin order");

    // R3 mu-law
    pair8(1'b0, 2'b01, 8'hFF, 8'h00, "R3 mu FF");
    pair8(1'b0, 2'b01, 8'h80, 8'h00, "R3 mu 80");
    pair8(1'b0, 2'b01, 8'h00, 8'h00, "R3 mu 00");
    pair8(1'b1, 2'b01, 8'h35, 8'hA7, "R3 mu stereo");

    // R4 16-bit low byte first
    pair16(1'b0, 16'h1234, 16'h0, "R4 mono");
    pair16(1'b1, 16'h8001, 16'h7FFE, "R4 stereo");

    // R6 no pair before last byte of a 16-bit stereo pair
    @(negedge clk); stereo = 1'b1; fmt = 2'b10;
    wr(8'h11); wr(8'h22); wr(8'h33);
    idle(1); #1;
    check("R6 partial", {31'h0, out_valid}, 32'h0);
    wr(8'h44);
    push(16'h2211, 16'h4433, "R6 complete");
    idle(2);

    // R7 format change discards a partial pair
    @(negedge clk); stereo = 1'b1; fmt = 2'b00;
    wr(8'h11);
    idle(1);
    stereo = 1'b0; fmt = 2'b10;
    idle(1);
    wr(8'h34); wr(8'h12);
    push(16'h1234, 16'h1234, "R7 after change");
    idle(2);
    // R7 write in the very cycle of the change
    @(negedge clk); stereo = 1'b1; fmt = 2'b00;
    wr(8'h55);
    @(negedge clk); stereo = 1'b1; fmt = 2'b01; wr_data = 8'hFF;
    wr(8'h80);
    push(ref_mu(8'hFF), ref_mu(8'h80), "R7 same cycle");
    idle(2);

    // R10 reserved layout ignored
    @(negedge clk); stereo = 1'b0; fmt = 2'b11;
    wr(8'h77); wr(8'h78);
    idle(2); #1;
    check("R10 no pair", {31'h0, out_valid}, 32'h0);
    pair8(1'b0, 2'b00, 8'h42, 8'h00, "R10 then lin");

    // R12 back-to-back completions with ready high
    @(negedge clk); stereo = 1'b0; fmt = 2'b00; out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wr(8'(8'h10 * i + 3));
      push(ref_lin(8'(8'h10 * i + 3)), ref_lin(8'(8'h10 * i + 3)), "R12 stream");
    end
    idle(2);
    check("R12 drained", sb.size(), 32'h0);

    // R8 / R9 hold and overrun
    @(negedge clk); out_ready = 1'b0; stereo = 1'b0; fmt = 2'b00;
    wr(8'h10);
    push(16'h9000, 16'h9000, "R8 held pair");
    idle(1);
    wr(8'h20);
    idle(1); #1;
    check("R9 overrun set", {31'h0, overrun}, 32'h1);
    check("R8 valid held", {31'h0, out_valid}, 32'h1);
    check("R8 left held", {16'h0, out_left}, 32'h9000);
    idle(2);
    out_ready = 1'b1;
    idle(3); #1;
    check("R9 dropped byte absent", sb.size(), 32'h0);
    check("R9 sticky", {31'h0, overrun}, 32'h1);
    do_reset();
    #1;
    check("R1 overrun cleared", {31'h0, overrun}, 32'h0);
    check("R1 valid cleared", {31'h0, out_valid}, 32'h0);

    // R11 capture read path
    @(negedge clk); rd_en = 1'b1; cap_byte = 8'h5A;
    #1 check("R11 read", {24'h0, rd_data}, 32'h5A);
    @(negedge clk); rd_en = 1'b0;
    #1 check("R11 idle", {24'h0, rd_data}, 32'h0);

    idle(3);
    check("R6 scoreboard empty", sb.size(), 32'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule